// File: doc/BRIEF.md
# Key Matrix Scan Controller

This block reads a matrix of 6 scan lines by 5 sense lines, 30 keys in all, and keeps a 30-bit word of debounced key states. While no key is down it does nothing: every scan line it owns is held high, so a press on any such row pulls a sense line high. The first scan tick that sees a sense line high starts a scan. Each tick then raises one scan line and samples the sense lines into that line's row.

A word is accepted only when two full scans in a row agree. When an accepted word differs from the word last reported, the block updates its output word and raises a ready flag. The flag stays up until the host acknowledges. Two controls change its behaviour. One stops scanning and holds the flag low. The other lends scan lines 1 to 3 to the display. Those lines are then driven low, and their rows always read as released. Once every key is up and a second all-zero scan confirms it, the block goes idle again.

Top module: `key_matrix_scan`

## Requirements
- R1: When idle, every scan line not lent to the display is driven high (scan_o = 6'b111111 with nothing lent).
- R2: During a scan, exactly one scan line is high. On each scan tick it moves from line 1 (scan_o[0]) to line 6 (scan_o[5]). The first line is raised on the tick that starts the scan.
- R3: No scan starts while every sense line is low; scan_o keeps its idle value and ready_o stays low.
- R4: With scan_en_i low, no scan starts and ready_o is held low even while keys are pressed.
- R5: With lend_i high, scan lines 1 to 3 are driven low at all times, and the key bits of those rows read 0. A press on those rows alone starts no scan.
- R6: A key at scan line s (1..6) and sense line k (1..5) maps to key_word_o bit (s-1)*5 + (k-1).
- R7: A word is accepted only when two consecutive full scans agree. With stable keys, the accepted word appears on the 13th scan tick counted from the starting tick.
- R8: ready_o rises on the same edge that an accepted word different from the last reported word is loaded into key_word_o. It falls on the edge after ack_i is sampled high.
- R9: When an all-zero scan is confirmed by a second all-zero scan, the zero word is reported and the block returns to idle on that same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan step strobe, one clock wide |
| scan_en_i | input | 1 | Enables key scanning |
| lend_i | input | 1 | Gives scan lines 1 to 3 to the display |
| sense_i | input | 5 | Sense lines, active high, pulled low when idle |
| ack_i | input | 1 | Host acknowledge; clears ready_o |
| scan_o | output | 6 | Scan line drives |
| key_word_o | output | 30 | Last reported debounced key word |
| ready_o | output | 1 | A new key word is waiting |

## Verification
Every result is counted in scan ticks from the tick that starts a scan. A stable press is reported on tick 13. A word that changes during the first scan is reported on tick 19. A release that follows a report on tick N is reported on tick N+12, with the block idle on that same tick. The ready flag falls one clock after the acknowledge. The driver tags each expected word with the tick count at which it is due. The monitor compares both the word and the tick count when ready rises, and it checks the clear one clock after it acknowledges. Scan line patterns are checked half a clock after the tick edge that changes them.

// File: rtl/kms_pkg.sv
`timescale 1ns/1ps
package kms_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} kms_state_e;
endpackage

// File: rtl/kms_sequencer.sv
`timescale 1ns/1ps
module kms_sequencer
  import kms_pkg::*;
#(
  parameter int N_SCAN = 6,
  parameter int N_LENT = 3,
  localparam int STEP_W = $clog2(N_SCAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              lend_i,
  input  logic              any_sense_i,
  input  logic              go_idle_i,
  output logic              scanning_o,
  output logic [STEP_W-1:0] step_o,
  output logic              step_last_o,
  output logic [N_SCAN-1:0] scan_o
);
  kms_state_e        state_q;
  logic [STEP_W-1:0] step_q;

  assign step_last_o = (step_q == STEP_W'(N_SCAN-1));
  assign scanning_o  = (state_q == ST_SCAN);
  assign step_o      = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (tick_i) begin
      case (state_q)
        ST_IDLE: if (any_sense_i) begin
          state_q <= ST_SCAN;
          step_q  <= '0;
        end
        default: begin
          if (step_last_o) begin
            step_q <= '0;
            if (go_idle_i) state_q <= ST_IDLE;
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < N_SCAN; i++) begin : g_line
    logic lent;
    assign lent      = lend_i && (i < N_LENT);
    assign scan_o[i] = !lent && (!scanning_o || step_q == STEP_W'(i));
  end

  assert_onehot_scan_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanning_o |-> $onehot0(scan_o));
  assert_step_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && scanning_o && !step_last_o) |=> (step_q == $past(step_q) + STEP_W'(1)));
  assert_no_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scanning_o && !any_sense_i) |=> !scanning_o);
  assert_disabled_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !scanning_o);
  assert_lent_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lend_i |-> (scan_o[N_LENT-1:0] == '0));
endmodule

// File: rtl/kms_capture.sv
`timescale 1ns/1ps
module kms_capture #(
  parameter int N_SCAN  = 6,
  parameter int N_SENSE = 5,
  parameter int N_LENT  = 3,
  localparam int STEP_W = $clog2(N_SCAN),
  localparam int KEYS   = N_SCAN * N_SENSE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               lend_i,
  input  logic               scanning_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic               step_last_i,
  input  logic [N_SENSE-1:0] sense_i,
  output logic               stable_o,
  output logic               all_zero_o,
  output logic [KEYS-1:0]    word_o
);
  logic [KEYS-1:0] frame_q, prev_q;
  logic            prev_vld_q;
  logic            frame_done;

  // merge the row under the current step into the partial frame
  for (genvar i = 0; i < N_SCAN; i++) begin : g_row
    logic lent;
    assign lent = lend_i && (i < N_LENT);
    assign word_o[i*N_SENSE +: N_SENSE] = lent ? '0 :
      (step_i == STEP_W'(i)) ? sense_i : frame_q[i*N_SENSE +: N_SENSE];
  end

  assign frame_done = scanning_i && tick_i && step_last_i;
  assign stable_o   = frame_done && prev_vld_q && (prev_q == word_o);
  assign all_zero_o = (word_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q    <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (!scanning_i) begin
      frame_q    <= '0;
      prev_vld_q <= 1'b0;
    end else if (tick_i) begin
      frame_q <= frame_done ? '0 : word_o;
      if (frame_done) begin
        prev_q     <= word_o;
        prev_vld_q <= 1'b1;
      end
    end
  end

  assert_lent_rows_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lend_i && stable_o) |-> (word_o[N_LENT*N_SENSE-1:0] == '0));
endmodule

// File: rtl/kms_report.sv
`timescale 1ns/1ps
module kms_report #(
  parameter int KEYS = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            stable_i,
  input  logic [KEYS-1:0] word_i,
  input  logic            ack_i,
  output logic [KEYS-1:0] key_word_o,
  output logic            ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_word_o <= '0;
      ready_o    <= 1'b0;
    end else if (!en_i) begin
      ready_o <= 1'b0;
    end else if (stable_i && word_i != key_word_o) begin
      key_word_o <= word_i;
      ready_o    <= 1'b1;
    end else if (ack_i) begin
      ready_o <= 1'b0;
    end
  end

  assert_word_change_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_word_o != $past(key_word_o)) |-> ready_o);
  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(stable_i && word_i != key_word_o)) |=> !ready_o);
  assert_ready_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ready_o);
endmodule

// File: rtl/key_matrix_scan.sv
`timescale 1ns/1ps
module key_matrix_scan #(
  parameter int N_SCAN  = 6,
  parameter int N_SENSE = 5,
  parameter int N_LENT  = 3,
  localparam int STEP_W = $clog2(N_SCAN),
  localparam int KEYS   = N_SCAN * N_SENSE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               scan_en_i,
  input  logic               lend_i,
  input  logic [N_SENSE-1:0] sense_i,
  input  logic               ack_i,
  output logic [N_SCAN-1:0]  scan_o,
  output logic [KEYS-1:0]    key_word_o,
  output logic               ready_o
);
  logic              scanning, step_last, stable, all_zero;
  logic [STEP_W-1:0] step;
  logic [KEYS-1:0]   cur_word;

  kms_sequencer #(.N_SCAN(N_SCAN), .N_LENT(N_LENT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .en_i        (scan_en_i),
    .lend_i      (lend_i),
    .any_sense_i (|sense_i),
    .go_idle_i   (stable && all_zero),
    .scanning_o  (scanning),
    .step_o      (step),
    .step_last_o (step_last),
    .scan_o      (scan_o)
  );

  kms_capture #(.N_SCAN(N_SCAN), .N_SENSE(N_SENSE), .N_LENT(N_LENT)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .lend_i      (lend_i),
    .scanning_i  (scanning),
    .step_i      (step),
    .step_last_i (step_last),
    .sense_i     (sense_i),
    .stable_o    (stable),
    .all_zero_o  (all_zero),
    .word_o      (cur_word)
  );

  kms_report #(.KEYS(KEYS)) u_rep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (scan_en_i),
    .stable_i   (stable),
    .word_i     (cur_word),
    .ack_i      (ack_i),
    .key_word_o (key_word_o),
    .ready_o    (ready_o)
  );

  assert_idle_after_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && stable && all_zero) |=> !scanning);
endmodule

// File: tb/key_matrix_scan_bench.sv
`timescale 1ns/1ps
module key_matrix_scan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        en = 1'b1;
  logic        lend = 1'b0;
  logic        ack = 1'b0;
  logic [4:0]  sense;
  logic [5:0]  scan;
  logic [29:0] word;
  logic        ready;
  logic [29:0] keys = '0;

  int checks = 0;
  int failures = 0;
  int tick_cnt = 0;
  bit done = 1'b0;

  typedef struct { logic [29:0] w; int due; string req; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  key_matrix_scan u_key_matrix_scan (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .scan_en_i(en), .lend_i(lend),
    .sense_i(sense), .ack_i(ack), .scan_o(scan), .key_word_o(word), .ready_o(ready)
  );

  // key matrix model: a sense line is high if a pressed key sits on a raised scan line
  always_comb begin
    sense = '0;
    for (int s = 0; s < 6; s++)
      for (int k = 0; k < 5; k++)
        if (scan[s] && keys[s*5+k]) sense[k] = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_tick();
    @(negedge clk); tick = 1'b1; tick_cnt++;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step_tick();
  endtask

  task automatic expect_word(input logic [29:0] w, input int due, input string req);
    item_t it;
    it.w = w; it.due = due; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: pops on each rising ready, compares word and due tick, acks and checks the clear
  logic ready_prev = 1'b0;
  bit   ack_pending = 1'b0;
  always @(negedge clk) begin
    if (ack_pending) begin
      check(!ready, "R8 clear", {31'd0, ready}, 32'd0);
      ack = 1'b0;
      ack_pending = 1'b0;
    end else if (ready && !ready_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected", {2'd0, word}, 32'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(word == it.w, it.req, {2'd0, word}, {2'd0, it.w});
        check(tick_cnt == it.due, {it.req, " tick"}, tick_cnt, it.due);
      end
      ack = 1'b1;
      ack_pending = 1'b1;
    end
    ready_prev = ready;
  end

  initial begin
    #(5ns * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    check(scan == 6'h3F, "R1 reset", scan, 6'h3F);
    check(ready == 1'b0, "R8 reset", ready, 0);
    check(word == '0, "R6 reset", word, 0);
    rst_n = 1'b1;

    // R3: no press, no scan
    ticks(20);
    check(scan == 6'h3F, "R3 idle", scan, 6'h3F);

    // line 2, sense 3 -> bit 7
    keys = 30'd1 << 7; st = tick_cnt + 1;
    expect_word(30'd1 << 7, st + 12, "R6 R7 single");
    step_tick();
    check(scan == 6'b000001, "R2 line1", scan, 6'b000001);
    step_tick();
    check(scan == 6'b000010, "R2 line2", scan, 6'b000010);
    ticks(4);
    check(scan == 6'b100000, "R2 line6", scan, 6'b100000);
    ticks(7);
    keys = '0;
    expect_word('0, st + 24, "R9 release");
    ticks(12);
    check(scan == 6'h3F, "R9 idle", scan, 6'h3F);

    // corner keys: line1 sense1 (bit 0) and line6 sense5 (bit 29)
    keys = (30'd1 << 0) | (30'd1 << 29); st = tick_cnt + 1;
    expect_word(keys, st + 12, "R6 R7 corners");
    ticks(13);
    keys = '0;
    expect_word('0, st + 24, "R9 corners");
    ticks(12);

    // bounce: bit 7 then bit 12 after the first scan
    keys = 30'd1 << 7; st = tick_cnt + 1;
    ticks(7);
    keys = 30'd1 << 12;
    expect_word(30'd1 << 12, st + 18, "R7 bounce");
    ticks(12);
    keys = '0;
    expect_word('0, st + 30, "R9 bounce");
    ticks(12);
    check(scan == 6'h3F, "R9 idle2", scan, 6'h3F);

    // R4: disabled
    en = 1'b0; keys = 30'd1 << 17;
    ticks(20);
    check(scan == 6'h3F, "R4 no scan", scan, 6'h3F);
    check(ready == 1'b0, "R4 ready", ready, 0);
    keys = '0;
    @(negedge clk); en = 1'b1;

    // R5: lent lines
    lend = 1'b1;
    @(negedge clk);
    check(scan == 6'b111000, "R5 R1 lent idle", scan, 6'b111000);
    keys = 30'd1 << 0;
    ticks(15);
    check(scan == 6'b111000, "R5 lent row no start", scan, 6'b111000);
    keys = (30'd1 << 0) | (30'd1 << 21); st = tick_cnt + 1;
    expect_word(30'd1 << 21, st + 12, "R5 R6 lent rows zero");
    step_tick();
    check(scan == 6'b000000, "R5 lent step", scan, 6'b000000);
    ticks(12);
    keys = '0;
    expect_word('0, st + 24, "R9 lent");
    ticks(12);
    check(scan == 6'b111000, "R9 lent idle", scan, 6'b111000);
    lend = 1'b0;

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R8 missing reports", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule